// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave for a Clock Generator

This block is a two-wire serial slave, of the kind found on SMBus and I2C management buses. It gives a host access to a bank of 22 byte-wide registers that configure a multi-output clock generator. It answers only to the 7-bit device address `1101001`, which is 0xD2 for a write and 0xD3 for a read. It supports four transfers:

- **Byte write**: the host sends one data byte to the register named in the command byte.
- **Byte read**: the host reads back the register named in the command byte.
- **Block write**: the host sends a byte count, then data bytes that fill the registers from offset 0 upward.
- **Block read**: the slave returns a byte count, then register contents from offset 0 upward.

The whole register image leaves the block as one flat parallel bus, with byte `k` at bits `[8k+7:8k]`. The clock-generator logic around the block decodes its enables, stop masks and drive modes from that bus. Two read-only status inputs appear live in one register byte: the latched frequency-select pair and the states of the three PCIe output-enable pins.

SCL and SDA are sampled by the system clock through a short synchronizer. Start and stop conditions are detected from SDA edges while SCL is high. SDA is open-drain: `sda_oe` high pulls the line low, and `sda_o` is held at 0.

The internal write port between the protocol engine and the register bank is a single-cycle valid strobe. It has no ready signal because the bank accepts a write in every cycle, so there is never back-pressure. The serial bus itself is paced only by the host's SCL. The block does not stretch the clock.

Top module: `cfgslv_top`

## Requirements
- R1: Only the address byte 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte gets no acknowledge, and the registers do not change until the next start condition.
- R2: After reset the register bytes hold these values:
  - 0: 0xEF; 1: 0xC0; 2: 0xFF; 3: 0xF0
  - 4: 0x3C; 5: 0x05; 6: 0x02; 7: 0x3F; 8: 0x46; 9: 0x06
  - 11: 0x81; 12: 0xA0; 13: 0x00; 14: 0x00
  - 15: 0x16; 16: 0x40; 17 to 21: 0x00
  - Byte 10 is the live status byte described in R9.
- R3: A byte write is start, 0xD2, command, data, stop. A command with bit 7 = 1 selects the register at offset bits 6:0. Data is shifted MSB first. The slave acknowledges the data byte, and each writable bit takes the new value. The writable-bit masks are:
  - 0: 0xEF; 1: 0xF8; 2: 0xFF; 3: 0x37
  - 15: 0xFF; 16: 0xC0; 17: 0xFF; 18: 0xFF; 19: 0x3F; 20: 0xFF; 21: 0xFF
  - All other bytes: 0x00
- R4: A byte read is start, 0xD2, command, repeated start, 0xD3, then one byte from the slave MSB first, then NACK and stop. The byte returned is the register selected by the command offset.
- R5: A block write is command 0x00, then a count N, then data bytes written to offsets 0, 1, 2 and onward.
  - Data bytes after the N-th are not acknowledged and not stored.
  - A stop after any complete byte keeps the bytes already written.
- R6: A block read is command 0x00, repeated start, 0xD3.
  - The slave first returns the content of register 15, then registers 0, 1, 2 and onward, for as long as the host acknowledges.
  - Offsets above 21 read as 0x00.
  - A host NACK ends the transfer.
- R7: A byte write to an offset above 21 gets no acknowledge on its data byte and changes no register. A byte read from such an offset returns 0x00.
- R8: A command byte with bit 7 = 0 and any of bits 6:0 set is not acknowledged.
- R9: Byte 10 reads as {freq_sel_i[1], freq_sel_i[0], pcie_en_i[2:0], 3'b000}, following the inputs. A write to it has no effect.
- R10: Read-only bytes and bits outside each write mask keep their value when written.
- R11: `sda_oe` changes only in the cycle after a detected SCL fall, start or stop. It is low after every stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_o | output | 1 | Data value driven when enabled, always 0 |
| sda_oe | output | 1 | High pulls SDA low |
| freq_sel_i | input | 2 | Latched frequency-select pair, high bit first |
| pcie_en_i | input | 3 | Levels of the three PCIe output-enable pins |
| cfg_o | output | 176 | Register image, byte k at bits [8k+7:8k] |

## Verification
The hardest situations to reach from the ports all involve a transfer that ends mid-stream:
- a host NACK partway through a block read that has run past offset 21;
- a block write that overruns its own count;
- a block write cut short by a stop before its count is used up.

The bench drives the bus as a wired-AND of its own pull-down and `sda_oe`, using bit-level host tasks. With these tasks it can stop, NACK or keep acknowledging after any byte. It tracks the expected register image arithmetically from the reset table and the write masks, and compares every byte at the parallel output and through serial reads.

// File: rtl/cfgslv_pkg.sv
`timescale 1ns/1ps
package cfgslv_pkg;
  localparam int NREG     = 22;
  localparam int BYTE_W   = 8;
  localparam int OFF_W    = 7;
  localparam int STAT_IDX = 10;
  localparam int CNT_IDX  = 15;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_CNT, PH_WR, PH_RD, PH_SKIP
  } phase_t;

  function automatic logic [BYTE_W-1:0] rst_val(input int idx);
    case (idx)
      0:  return 8'hEF;
      1:  return 8'hC0;
      2:  return 8'hFF;
      3:  return 8'hF0;
      4:  return 8'h3C;
      5:  return 8'h05;
      6:  return 8'h02;
      7:  return 8'h3F;
      8:  return 8'h46;
      9:  return 8'h06;
      11: return 8'h81;
      12: return 8'hA0;
      15: return 8'h16;
      16: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] wr_mask(input int idx);
    case (idx)
      0:  return 8'hEF;
      1:  return 8'hF8;
      2:  return 8'hFF;
      3:  return 8'h37;
      15: return 8'hFF;
      16: return 8'hC0;
      17, 18, 20, 21: return 8'hFF;
      19: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgslv_sync.sv
`timescale 1ns/1ps
module cfgslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic rise_ev,
  output logic fall_ev,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign rise_ev  = scl_s & ~scl_q;
  assign fall_ev  = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgslv_regs.sv
`timescale 1ns/1ps
module cfgslv_regs
  import cfgslv_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [OFF_W-1:0]       wr_idx,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [BYTE_W-1:0]      status,
  input  logic [OFF_W-1:0]       rd_idx,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [NREG*BYTE_W-1:0] image
);
  localparam int SEL_W = $clog2(NREG);

  logic [BYTE_W-1:0] view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    if (g == STAT_IDX) begin : g_stat
      assign view[g] = status;
    end else begin : g_store
      localparam logic [BYTE_W-1:0] MASK = wr_mask(g);
      logic [BYTE_W-1:0] bank;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank <= rst_val(g);
        else if (wr_valid && wr_idx == OFF_W'(g))
          bank <= (bank & ~MASK) | (wr_data & MASK);
      end
      assign view[g] = bank;
    end
    assign image[g*BYTE_W +: BYTE_W] = view[g];
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx < OFF_W'(NREG)) rd_data = view[rd_idx[SEL_W-1:0]];
  end
endmodule

// File: rtl/cfgslv_engine.sv
`timescale 1ns/1ps
module cfgslv_engine
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [OFF_W-1:0]  rd_idx,
  output logic              wr_valid,
  output logic [OFF_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  phase_t             phase;
  logic [3:0]         cnt;
  logic               in_ack, blk, cnt_first, active, byte_done, wr_ok;
  logic [BYTE_W-1:0]  sh, tx, remain;
  logic [OFF_W-1:0]   ptr, ptr_nx;

  always_comb begin
    active    = (phase != PH_IDLE) && (phase != PH_SKIP);
    byte_done = fall_ev && !in_ack && (cnt == 4'd8) && (phase != PH_RD);
    wr_ok     = (remain != '0) && (ptr < OFF_W'(NREG));
    wr_valid  = active && byte_done && (phase == PH_WR) && wr_ok;
    wr_idx    = ptr;
    wr_data   = sh;
    rd_idx    = cnt_first ? OFF_W'(CNT_IDX) : ptr;
    ptr_nx    = (ptr == '1) ? ptr : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      sh <= '0; tx <= '0; remain <= '0; ptr <= '0; blk <= 1'b0; cnt_first <= 1'b0;
    end else if (start_ev) begin
      phase <= PH_ADDR; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      phase <= PH_IDLE; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (active) begin
      if (rise_ev) begin
        if (!in_ack) begin
          sh  <= {sh[BYTE_W-2:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (phase == PH_RD && sda_s) begin
          phase <= PH_SKIP;                 // host NACK ends the read
        end
      end
      if (fall_ev) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          if (phase == PH_RD) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[BYTE_W-1];
            if (cnt_first) cnt_first <= 1'b0;
            else           ptr       <= ptr_nx;
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (phase == PH_RD) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            in_ack <= 1'b1;
          end else begin
            sda_oe <= ~tx[BYTE_W-2];
            tx     <= {tx[BYTE_W-2:0], 1'b0};
          end
        end else if (cnt == 4'd8) begin
          in_ack <= 1'b1;
          cnt    <= '0;
          sda_oe <= 1'b0;
          case (phase)
            PH_ADDR: begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe    <= 1'b1;
                phase     <= sh[0] ? PH_RD : PH_CMD;
                cnt_first <= sh[0] & blk;
              end else phase <= PH_SKIP;
            end
            PH_CMD: begin
              if (sh[7]) begin
                sda_oe <= 1'b1; phase <= PH_WR;
                ptr <= sh[6:0]; blk <= 1'b0; remain <= 8'd1;
              end else if (sh[6:0] == '0) begin
                sda_oe <= 1'b1; phase <= PH_CNT;
                ptr <= '0; blk <= 1'b1;
              end else phase <= PH_SKIP;
            end
            PH_CNT: begin
              sda_oe <= 1'b1; phase <= PH_WR; remain <= sh;
            end
            PH_WR: begin
              if (wr_ok) begin
                sda_oe <= 1'b1;
                ptr    <= ptr_nx;
                remain <= remain - 8'd1;
              end else phase <= PH_SKIP;
            end
            default: phase <= PH_SKIP;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfgslv_top.sv
`timescale 1ns/1ps
module cfgslv_top
  import cfgslv_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_o,
  output logic                   sda_oe,
  input  logic [1:0]             freq_sel_i,
  input  logic [2:0]             pcie_en_i,
  output logic [NREG*BYTE_W-1:0] cfg_o
);
  logic scl_s, sda_s, rise_ev, fall_ev, start_ev, stop_ev;
  logic wr_valid;
  logic [OFF_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data, status;

  assign status = {freq_sel_i, pcie_en_i, 3'b000};
  assign sda_o  = 1'b0;

  cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  cfgslv_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfgslv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .status(status), .rd_idx(rd_idx),
    .rd_data(rd_data), .image(cfg_o)
  );
endmodule

// File: rtl/cfgslv_chk.sv
`timescale 1ns/1ps
module cfgslv_chk
  import cfgslv_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sda_oe,
  input logic                   scl_s,
  input logic                   fall_ev,
  input logic                   start_ev,
  input logic                   stop_ev,
  input logic [1:0]             freq_sel_i,
  input logic [2:0]             pcie_en_i,
  input logic [NREG*BYTE_W-1:0] cfg_o
);
  localparam logic [NREG*BYTE_W-1:0] LIVE =
    {{(NREG*BYTE_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << (STAT_IDX*BYTE_W);

  // R11
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(fall_ev) || $past(start_ev) || $past(stop_ev)));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !$past(start_ev)) |-> !scl_s);

  // R10
  ro_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[11*BYTE_W +: BYTE_W] == 8'h81) && (cfg_o[12*BYTE_W+4 +: 4] == 4'hA));

  // R9
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[STAT_IDX*BYTE_W +: BYTE_W] == {freq_sel_i, pcie_en_i, 3'b000});

  // R3
  write_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> ((cfg_o & ~LIVE) == ($past(cfg_o) & ~LIVE)));
endmodule

bind cfgslv_top cfgslv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .fall_ev(fall_ev), .start_ev(start_ev), .stop_ev(stop_ev),
  .freq_sel_i(freq_sel_i), .pcie_en_i(pcie_en_i), .cfg_o(cfg_o)
);

// File: tb/tb_cfgslv_top.sv
`timescale 1ns/1ps
module tb_cfgslv_top;
  localparam int NR = 22;
  localparam int Q  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, hlow = 1'b0;
  logic [1:0] fsel = 2'b10;
  logic [2:0] pen  = 3'b101;
  logic sda_o, sda_oe;
  logic [NR*8-1:0] cfg;
  wire sda_line = ~(hlow | sda_oe);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m [NR];
  logic [7:0] msk [NR];

  always #4 clk = ~clk;

  cfgslv_top dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .freq_sel_i(fsel),
    .pcie_en_i(pen), .cfg_o(cfg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expb(input int i);
    return (i == 10) ? {fsel, pen, 3'b000} : (i < NR ? m[i] : 8'h00);
  endfunction

  task automatic check_image(input string tag);
    int bad = 0;
    for (int i = 0; i < NR; i++)
      if (cfg[i*8 +: 8] != expb(i)) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic tq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    hlow = 1'b0; tq; scl = 1'b1; tq; hlow = 1'b1; tq; scl = 1'b0; tq;
  endtask

  task automatic i2c_stop;
    hlow = 1'b1; tq; scl = 1'b1; tq; hlow = 1'b0; tq;
  endtask

  task automatic put_bit(input logic b);
    hlow = ~b; tq; scl = 1'b1; tq; tq; scl = 1'b0; tq;
  endtask

  task automatic get_bit(output logic b);
    hlow = 1'b0; tq; scl = 1'b1; tq; b = sda_line; tq; scl = 1'b0; tq;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~give_ack);
  endtask

  task automatic byte_write(input int off, input logic [7:0] v, output logic ackd);
    logic a;
    i2c_start;
    put_byte(8'hD2, a);
    put_byte({1'b1, 7'(off)}, a);
    put_byte(v, ackd);
    i2c_stop;
  endtask

  task automatic byte_read(input int off, output logic [7:0] v);
    logic a;
    i2c_start;
    put_byte(8'hD2, a);
    put_byte({1'b1, 7'(off)}, a);
    i2c_start;
    put_byte(8'hD3, a);
    get_byte(1'b0, v);
    i2c_stop;
  endtask

  task automatic model_write(input int i, input logic [7:0] v);
    m[i] = (m[i] & ~msk[i]) | (v & msk[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, a2;
    logic [7:0] v;
    m = '{8'hEF, 8'hC0, 8'hFF, 8'hF0, 8'h3C, 8'h05, 8'h02, 8'h3F, 8'h46, 8'h06, 8'h00,
          8'h81, 8'hA0, 8'h00, 8'h00, 8'h16, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    msk = '{8'hEF, 8'hF8, 8'hFF, 8'h37, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
            8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hC0, 8'hFF, 8'hFF, 8'h3F, 8'hFF, 8'hFF};
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 reset image, byte by byte
    for (int i = 0; i < NR; i++) chk($sformatf("R2 reset byte %0d", i), cfg[i*8 +: 8], expb(i));
    chk("R11 idle sda_oe", sda_oe, 0);

    // R3 / R10 / R9: byte write to every offset
    for (int i = 0; i < NR; i++) begin
      v = 8'(i * 73 + 29) ^ 8'h5A;
      byte_write(i, v, a);
      chk($sformatf("R3 data ack off %0d", i), a, 1);
      model_write(i, v);
      chk($sformatf("%s byte %0d after write", msk[i] == 8'h00 ? "R10" : "R3", i),
          cfg[i*8 +: 8], expb(i));
    end
    chk("R11 released after stop", sda_oe, 0);

    // R4: byte read from every offset
    for (int i = 0; i < NR; i++) begin
      byte_read(i, v);
      chk($sformatf("R4 read off %0d", i), v, expb(i));
    end

    // R7: offsets above 21
    for (int k = 0; k < 4; k++) begin
      int off = (k == 3) ? 127 : 22 + k * 9;
      byte_write(off, 8'hFF, a);
      chk($sformatf("R7 nack off %0d", off), a, 0);
      byte_read(off, v);
      chk($sformatf("R7 read off %0d", off), v, 0);
    end
    check_image("R7 image unchanged");

    // R1: foreign addresses
    i2c_start; put_byte(8'hD0, a); put_byte(8'h81, a2); put_byte(8'h00, a2); i2c_stop;
    chk("R1 nack addr D0", a, 0);
    i2c_start; put_byte(8'hA4, a); i2c_stop;
    chk("R1 nack addr A4", a, 0);
    check_image("R1 image unchanged");

    // R5: block write with count 4, fifth byte refused
    i2c_start; put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'd4, a);
    chk("R5 count ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      v = 8'(8'h11 * (i + 3));
      put_byte(v, a);
      chk($sformatf("R5 data ack %0d", i), a, 1);
      model_write(i, v);
    end
    put_byte(8'h00, a);
    chk("R5 over-count nack", a, 0);
    i2c_stop;
    check_image("R5 image after block");

    // R5: early stop after two of six
    i2c_start; put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'd6, a);
    put_byte(8'h12, a); model_write(0, 8'h12);
    put_byte(8'h34, a); model_write(1, 8'h34);
    i2c_stop;
    check_image("R5 image after early stop");

    // R6: block read with changed count register, running past offset 21
    byte_write(15, 8'h09, a); model_write(15, 8'h09);
    i2c_start; put_byte(8'hD2, a); put_byte(8'h00, a);
    i2c_start; put_byte(8'hD3, a);
    chk("R6 read addr ack", a, 1);
    get_byte(1'b1, v);
    chk("R6 count byte", v, m[15]);
    for (int i = 0; i < 24; i++) begin
      get_byte(i != 23, v);
      chk($sformatf("R6 block byte %0d", i), v, expb(i));
    end
    i2c_stop;
    chk("R11 released after block read", sda_oe, 0);

    // R8: malformed block command
    i2c_start; put_byte(8'hD2, a); put_byte(8'h05, a); i2c_stop;
    chk("R8 nack cmd 05", a, 0);
    check_image("R8 image unchanged");

    // R9: live status
    fsel = 2'b01; pen = 3'b010;
    repeat (3) @(negedge clk);
    chk("R9 status port", cfg[10*8 +: 8], 8'h50);
    byte_read(10, v);
    chk("R9 status read", v, 8'h50);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule